// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects up to 71 level-sensitive interrupt lines and routes each of them to one of two interrupt outputs. Every source owns a request register holding a four-bit priority, an enable, an input-polarity selector and a target selector. A write may touch any mix of these fields, because each field carries its own write-enable bit in the same word. A field whose write-enable is clear keeps its old value, so software can update one field without first reading the register.

Each output target owns a priority threshold and a vector register. A source competes for a target when all of these hold: its polarity-corrected line is active, it is enabled, it is routed to that target, and its priority is strictly above the threshold. A priority of zero therefore never signals. Among the competing sources, the highest priority wins and the lowest index breaks ties. The vector register reads back the winning index shifted left by three. A value of zero means nothing is pending, which is why source 0 is reserved and never configurable. Arbitration runs every cycle with no latching, and the output and vector registers follow the inputs with one cycle of delay.

Top module: `prio_vic`

## Requirements
- R1: After reset, every request register reads 0, both thresholds read 0, both vectors read 0 and both interrupt outputs are low.
- R2: A request-register write changes the priority field (bits 3:0) only when bit 28 of the written word is set. Otherwise the stored priority is kept.
- R3: The enable (bit 16) changes only when bit 26 is set in the same write. A disabled source never wins.
- R4: The polarity bit (bit 17) changes only when bit 27 is set in the same write. When the polarity bit is 1 the source line is active low; when it is 0 the line is active high.
- R5: The target selector (bit 24) changes only when bit 25 is set in the same write. The value 0 routes the source to output 0 and the value 1 routes it to output 1.
- R6: Source 0 is reserved. Writes to address 0 are ignored, it reads 0, and it never wins.
- R7: A source competes only when its priority is strictly greater than the threshold of its target. Thresholds are at address 0x80 (target 0) and 0x82 (target 1), hold 4 bits and can be read back.
- R8: The highest competing priority wins, and ties go to the lowest source index.
- R9: The vector registers at 0x81 (target 0) and 0x83 (target 1) read as winner index << 3, or 0 when nothing competes. The output of a target is high exactly when something competes for it. Both the vector and the output follow the inputs one clock later, up to the highest source index.
- R10: Inputs are not latched. When a line goes inactive, its request disappears from the output and the vector one clock later.
- R11: Request register k (k from 1 to 70) is read at address k and returns the priority in bits 3:0, the enable in bit 16, the polarity in bit 17 and the target in bit 24, with all other bits 0.
- R12: A source with priority 0 never wins, even when the threshold is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 8 | Word address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_in | input | 71 | Raw interrupt lines, one per source |
| irq_o | output | 2 | Interrupt output per target |

## Verification
The bench builds the block with its default parameters: 71 sources, two targets and an 8-bit address. With these values the highest source index, 70, gives a vector value of 560. The address map is exercised right up to the reserved source 0 and to the threshold and vector words above 0x80. Both targets are used, so routing a source away from output 0 and back can be observed on the outputs and in both vector registers.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int PRIO_W  = 4;
    localparam int NUM_TGT = 2;
    localparam int DATA_W  = 32;

    // field positions in a request word
    localparam int B_EN      = 16;
    localparam int B_POL     = 17;
    localparam int B_TGT     = 24;
    localparam int B_WE_TGT  = 25;
    localparam int B_WE_EN   = 26;
    localparam int B_WE_POL  = 27;
    localparam int B_WE_PRIO = 28;

    typedef struct packed {
        logic              tgt;
        logic              pol;
        logic              en;
        logic [PRIO_W-1:0] prio;
    } req_t;

    function automatic logic [DATA_W-1:0] pack_req(input req_t r);
        logic [DATA_W-1:0] w;
        w                  = '0;
        w[PRIO_W-1:0]      = r.prio;
        w[B_EN]            = r.en;
        w[B_POL]           = r.pol;
        w[B_TGT]           = r.tgt;
        return w;
    endfunction
endpackage

// File: rtl/vic_srcregs.sv
module vic_srcregs
    import vic_pkg::*;
#(
    parameter int NUM_SRC = 71,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wdata,
    output req_t              regs [NUM_SRC]
);
    // source 0 is reserved and stays zero
    assign regs[0] = '0;

    for (genvar i = 1; i < NUM_SRC; i++) begin : g_src
        logic hit;
        assign hit = wr_en && (wr_idx == IDX_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[i] <= '0;
            end else if (hit) begin
                if (wdata[B_WE_PRIO]) regs[i].prio <= wdata[PRIO_W-1:0];
                if (wdata[B_WE_EN])   regs[i].en   <= wdata[B_EN];
                if (wdata[B_WE_POL])  regs[i].pol  <= wdata[B_POL];
                if (wdata[B_WE_TGT])  regs[i].tgt  <= wdata[B_TGT];
            end
        end
    end
endmodule

// File: rtl/vic_arb.sv
module vic_arb
    import vic_pkg::*;
#(
    parameter int NUM_SRC = 71,
    parameter int IDX_W   = $clog2(NUM_SRC),
    parameter int TGT_ID  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_SRC-1:0] eligible,
    input  logic [NUM_SRC-1:0] tgt_sel,
    input  logic [PRIO_W-1:0] prio [NUM_SRC],
    input  logic [PRIO_W-1:0] mask,
    output logic              irq,
    output logic [IDX_W-1:0]  win_idx
);
    logic [NUM_SRC-1:0] pend;
    logic [PRIO_W-1:0]  best_p;
    logic [IDX_W-1:0]   best_i;
    logic               any;

    always_comb begin
        pend[0] = 1'b0;
        for (int i = 1; i < NUM_SRC; i++) begin
            pend[i] = eligible[i] && (tgt_sel[i] == 1'(TGT_ID)) && (prio[i] > mask);
        end
    end

    // scan downward so equal priority lands on the lower index
    always_comb begin
        best_p = '0;
        best_i = '0;
        any    = 1'b0;
        for (int i = NUM_SRC - 1; i >= 1; i--) begin
            if (pend[i] && (prio[i] >= best_p)) begin
                best_p = prio[i];
                best_i = IDX_W'(i);
                any    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq     <= 1'b0;
            win_idx <= '0;
        end else begin
            irq     <= any;
            win_idx <= any ? best_i : '0;
        end
    end
endmodule

// File: rtl/prio_vic.sv
module prio_vic
    import vic_pkg::*;
#(
    parameter int NUM_SRC = 71,
    parameter int ADDR_W  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [NUM_SRC-1:0]   irq_in,
    output logic [NUM_TGT-1:0]   irq_o
);
    localparam int IDX_W    = $clog2(NUM_SRC);
    localparam int TGT_BASE = 2 ** (ADDR_W - 1);

    req_t               src_regs [NUM_SRC];
    logic [PRIO_W-1:0]  prio_arr [NUM_SRC];
    logic [NUM_SRC-1:0] en_vec;
    logic [NUM_SRC-1:0] tgt_vec;
    logic [NUM_SRC-1:0] eligible;
    logic [PRIO_W-1:0]  mask_q   [NUM_TGT];
    logic [IDX_W-1:0]   win_idx  [NUM_TGT];
    logic               src_wr;

    assign src_wr = bus_wr && (bus_addr < ADDR_W'(NUM_SRC));

    vic_srcregs #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (src_wr),
        .wr_idx (bus_addr[IDX_W-1:0]),
        .wdata  (bus_wdata),
        .regs   (src_regs)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_flat
        assign prio_arr[i] = src_regs[i].prio;
        assign en_vec[i]   = src_regs[i].en;
        assign tgt_vec[i]  = src_regs[i].tgt;
        assign eligible[i] = (irq_in[i] ^ src_regs[i].pol) && src_regs[i].en;
    end

    for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_q[t] <= '0;
            end else if (bus_wr && (bus_addr == ADDR_W'(TGT_BASE + 2 * t))) begin
                mask_q[t] <= bus_wdata[PRIO_W-1:0];
            end
        end

        vic_arb #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .TGT_ID(t)) u_arb (
            .clk      (clk),
            .rst_n    (rst_n),
            .eligible (eligible),
            .tgt_sel  (tgt_vec),
            .prio     (prio_arr),
            .mask     (mask_q[t]),
            .irq      (irq_o[t]),
            .win_idx  (win_idx[t])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr < ADDR_W'(NUM_SRC)) begin
            bus_rdata = pack_req(src_regs[bus_addr[IDX_W-1:0]]);
        end else begin
            for (int t = 0; t < NUM_TGT; t++) begin
                if (bus_addr == ADDR_W'(TGT_BASE + 2 * t)) begin
                    bus_rdata[PRIO_W-1:0] = mask_q[t];
                end
                if (bus_addr == ADDR_W'(TGT_BASE + 2 * t + 1)) begin
                    bus_rdata[IDX_W+2:0] = {win_idx[t], 3'b000};
                end
            end
        end
    end
endmodule

// File: rtl/vic_chk.sv
module vic_chk
    import vic_pkg::*;
#(
    parameter int NUM_SRC = 71,
    parameter int ADDR_W  = 8,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               we_prio,
    input logic               we_en,
    input logic [PRIO_W-1:0]  rd_prio,
    input logic               rd_en,
    input logic [NUM_TGT-1:0] irq_o,
    input logic [PRIO_W-1:0]  prio_arr [NUM_SRC],
    input logic [NUM_SRC-1:0] en_vec,
    input logic [NUM_SRC-1:0] tgt_vec,
    input logic [PRIO_W-1:0]  mask_q   [NUM_TGT],
    input logic [IDX_W-1:0]   win_idx  [NUM_TGT]
);
    logic [PRIO_W-1:0]  prev_prio [NUM_SRC];
    logic [NUM_SRC-1:0] prev_en;
    logic [NUM_SRC-1:0] prev_tgt;
    logic [PRIO_W-1:0]  prev_mask [NUM_TGT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SRC; i++) prev_prio[i] <= '0;
            for (int t = 0; t < NUM_TGT; t++) prev_mask[t] <= '0;
            prev_en  <= '0;
            prev_tgt <= '0;
        end else begin
            prev_prio <= prio_arr;
            prev_mask <= mask_q;
            prev_en   <= en_vec;
            prev_tgt  <= tgt_vec;
        end
    end

    // R2: priority kept when its write-enable is clear
    a_r2_prio_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !we_prio && (bus_addr < ADDR_W'(NUM_SRC)))
        |=> ((bus_addr != $past(bus_addr)) || (rd_prio == $past(rd_prio))));

    // R3: enable kept when its write-enable is clear
    a_r3_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !we_en && (bus_addr < ADDR_W'(NUM_SRC)))
        |=> ((bus_addr != $past(bus_addr)) || (rd_en == $past(rd_en))));

    for (genvar t = 0; t < NUM_TGT; t++) begin : g_t
        // R6: a raised output never names source 0
        a_r6_no_src0: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[t] |-> (win_idx[t] != '0));

        // R7: winner was above the threshold when it was chosen
        a_r7_above_mask: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[t] |-> (prev_prio[win_idx[t]] > prev_mask[t]));

        // R3: winner was enabled
        a_r3_winner_enabled: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[t] |-> prev_en[win_idx[t]]);

        // R5: winner was routed to this target
        a_r5_winner_routed: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[t] |-> (prev_tgt[win_idx[t]] == 1'(t)));
    end
endmodule

bind prio_vic vic_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .we_prio  (bus_wdata[28]),
    .we_en    (bus_wdata[26]),
    .rd_prio  (bus_rdata[3:0]),
    .rd_en    (bus_rdata[16]),
    .irq_o    (irq_o),
    .prio_arr (prio_arr),
    .en_vec   (en_vec),
    .tgt_vec  (tgt_vec),
    .mask_q   (mask_q),
    .win_idx  (win_idx)
);

// File: tb/prio_vic_tb.sv
module prio_vic_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 71;

    localparam logic [31:0] WP   = 32'h1000_0000;
    localparam logic [31:0] WPOL = 32'h0800_0000;
    localparam logic [31:0] WE   = 32'h0400_0000;
    localparam logic [31:0] WT   = 32'h0200_0000;
    localparam logic [31:0] TGT  = 32'h0100_0000;
    localparam logic [31:0] POL  = 32'h0002_0000;
    localparam logic [31:0] EN   = 32'h0001_0000;
    localparam logic [7:0]  MASK0 = 8'h80, VEC0 = 8'h81, MASK1 = 8'h82, VEC1 = 8'h83;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_wr = 0;
    logic [7:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic [NSRC-1:0] irq_in = '0;
    logic [1:0]  irq_o;

    typedef struct {
        logic [7:0]  addr;
        logic [31:0] data;
        logic [1:0]  irq;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 0;

    prio_vic u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in), .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic set_in(input int idx, input logic v);
        @(negedge clk);
        irq_in[idx] = v;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // driver: point the bus at a word and queue what must be seen there
    task automatic chk(input logic [7:0] a, input logic [31:0] d,
                       input logic [1:0] q, input string tag);
        exp_t e;
        idle(3);
        bus_addr = a;
        e.addr = a; e.data = d; e.irq = q; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    // monitor: compare queued items away from the clock edge
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_run++;
                if (bus_rdata !== e.data || irq_o !== e.irq) begin
                    n_fail++;
                    $display("FAIL %s addr=%h rdata=%h irq=%b expected rdata=%h irq=%b",
                             e.tag, e.addr, bus_rdata, irq_o, e.data, e.irq);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        idle(2);
        rst_n = 1;

        chk(8'd5, 32'h0, 2'b00, "R1 src5 reset");
        chk(VEC0, 32'h0, 2'b00, "R1 vec0 reset");
        chk(MASK0, 32'h0, 2'b00, "R1 mask0 reset");
        chk(VEC1, 32'h0, 2'b00, "R1 vec1 reset");

        wr(8'd5, WP | 32'd3);
        chk(8'd5, 32'h3, 2'b00, "R2 prio write");
        wr(8'd5, 32'd7);
        chk(8'd5, 32'h3, 2'b00, "R2 prio held");

        wr(8'd5, EN);
        chk(8'd5, 32'h3, 2'b00, "R3 enable held");
        wr(8'd5, WE | EN);
        chk(8'd5, 32'h0001_0003, 2'b00, "R3 enable set");

        set_in(5, 1);
        chk(VEC0, 32'd40, 2'b01, "R9 single source");
        set_in(5, 0);
        chk(VEC0, 32'd0, 2'b00, "R10 line dropped");

        wr(8'd5, WPOL | POL);
        chk(8'd5, 32'h0003_0003, 2'b01, "R4 polarity set");
        chk(VEC0, 32'd40, 2'b01, "R4 active low low");
        set_in(5, 1);
        chk(VEC0, 32'd0, 2'b00, "R4 active low high");
        wr(8'd5, WPOL);
        chk(VEC0, 32'd40, 2'b01, "R4 back to active high");

        wr(8'd5, WT | TGT);
        chk(VEC0, 32'd0, 2'b10, "R5 left target 0");
        chk(VEC1, 32'd40, 2'b10, "R5 on target 1");
        chk(8'd5, 32'h0101_0003, 2'b10, "R11 target readback");
        wr(8'd5, 32'h0);
        chk(VEC1, 32'd40, 2'b10, "R5 target held");
        wr(8'd5, WT);
        chk(VEC0, 32'd40, 2'b01, "R5 back to target 0");

        wr(8'd9, WP | WE | EN | 32'd3);
        wr(8'd12, WP | WE | EN | 32'd6);
        set_in(9, 1);
        set_in(12, 1);
        chk(VEC0, 32'd96, 2'b01, "R8 highest priority");
        wr(8'd12, WP | 32'd3);
        chk(VEC0, 32'd40, 2'b01, "R8 tie lowest index");
        wr(8'd9, WP | 32'd15);
        chk(VEC0, 32'd72, 2'b01, "R8 priority over index");

        wr(MASK0, 32'd14);
        chk(VEC0, 32'd72, 2'b01, "R7 mask 14");
        wr(MASK0, 32'd15);
        chk(VEC0, 32'd0, 2'b00, "R7 mask 15");
        wr(MASK0, 32'd3);
        chk(VEC0, 32'd72, 2'b01, "R7 mask 3");
        wr(8'd9, WP | 32'd3);
        chk(VEC0, 32'd0, 2'b00, "R7 equal is blocked");
        chk(MASK0, 32'd3, 2'b00, "R7 mask readback");
        chk(MASK1, 32'd0, 2'b00, "R7 other mask untouched");

        wr(MASK0, 32'd0);
        chk(VEC0, 32'd40, 2'b01, "R8 three way tie");
        wr(8'd5, WP);
        chk(VEC0, 32'd72, 2'b01, "R12 priority zero");
        wr(8'd9, WE);
        chk(VEC0, 32'd96, 2'b01, "R3 disabled loses");

        set_in(0, 1);
        wr(8'd0, WP | WE | WPOL | WT | EN | 32'd15);
        chk(8'd0, 32'h0, 2'b01, "R6 src0 reads zero");
        chk(VEC0, 32'd96, 2'b01, "R6 src0 never wins");

        wr(8'd70, WP | WE | EN | 32'd15);
        set_in(70, 1);
        chk(VEC0, 32'd560, 2'b01, "R9 top index");
        set_in(70, 0);
        chk(VEC0, 32'd96, 2'b01, "R10 top dropped");
        set_in(12, 0);
        chk(VEC0, 32'd0, 2'b00, "R10 all dropped");
        chk(8'd12, 32'h0001_0003, 2'b00, "R11 readback src12");
        chk(8'd9, 32'h0000_0003, 2'b00, "R11 readback src9");

        idle(3);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule